// File: doc/BRIEF.md
# Dual-Wire Command Byte Receiver

This block sits on the target side of a serial link and turns serial traffic into command bytes. A host drives a serial clock, an active-low select and either one or two data lines. In single-wire mode each rising serial-clock edge brings one bit, so a byte takes eight edges. In dual-wire mode each edge brings two bits, so a byte takes four edges. The second data line is a spare pin that the bus also uses as a select for other devices. A command is framed by its select: the host raises the select after every command, and that ends the frame.

All serial inputs are sampled by the system clock through multi-flop synchronizers. The block finds serial-clock rising edges on the synchronized copy. Each completed byte is presented for one system-clock cycle with its value. The first byte of a frame carries a marker that identifies it as the command byte. The select is shared with another device, so the block ignores clock edges while it is not selected. A partly assembled byte is dropped when the select goes high.

Top module: `dwr_cmd_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, `byte_valid_o`, `byte_data_o` and `byte_is_cmd_o` are all zero.
- R2: In single-wire mode (`dual_i`=0), eight rising serial-clock edges with the select low deliver one byte. Bits are taken from `d0_i` most significant first, and `d1_i` is ignored.
- R3: In dual-wire mode (`dual_i`=1), four rising serial-clock edges deliver one byte. Each edge yields a bit pair: `d0_i` is the upper bit and `d1_i` the lower bit. The pairs arrive in the order bits 7:6, 5:4, 3:2, 1:0.
- R4: `byte_valid_o` is high for exactly one system-clock cycle per completed byte. `byte_data_o` holds the last byte until the next byte completes.
- R5: The first byte completed after the select falls has `byte_is_cmd_o`=1. Every later byte in the same frame has `byte_is_cmd_o`=0.
- R6: A rising select discards any partial byte. The next frame starts from bit zero, and its first byte is again the command byte.
- R7: Serial-clock edges while the select is high produce no byte and leave the bit count unchanged.
- R8: The mode is captured when the select falls. Changing `dual_i` inside a frame has no effect until the next frame.
- R9: A final serial-clock edge that reaches the synchronized domain in the same cycle as a rising select is ignored, and no byte is delivered.
- R10: Back-to-back bytes in one frame, with no idle edges between them, are each delivered in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from host |
| sel_n_i | input | 1 | Active-low select; high ends a frame |
| d0_i | input | 1 | Main data line (upper bit in dual mode) |
| d1_i | input | 1 | Spare data line (lower bit in dual mode) |
| dual_i | input | 1 | Mode strap: 1 = two bits per edge, 0 = one bit |
| byte_valid_o | output | 1 | One-cycle strobe for a completed byte |
| byte_data_o | output | 8 | Value of the last completed byte |
| byte_is_cmd_o | output | 1 | Marks the strobed byte as the first of its frame |

## Verification
Two functions can fall in the same synchronized cycle: the serial-clock edge that completes a byte, and the rising select that ends the frame. The bench provokes this by changing the serial clock and the select in the same time step after seven bits. It then checks that no strobe appears, and that the next frame delivers its first byte with the command marker. The same check covers the opposite collision, where the select falls together with the first clock edge of a frame, and that edge must count.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  localparam int SYNC_W  = 5;
  localparam int IDX_D0  = 0;
  localparam int IDX_D1  = 1;
  localparam int IDX_CLK = 2;
  localparam int IDX_SEL = 3;
  localparam int IDX_MOD = 4;
  localparam logic [SYNC_W-1:0] SYNC_RST = 5'b01000;
endpackage

// File: rtl/dwr_sync.sv
module dwr_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/dwr_shifter.sv
module dwr_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              bit_en,
  input  logic              dual,
  input  logic              d0,
  input  logic              d1,
  output logic              done,
  output logic [BYTE_W-1:0] word
);
  localparam int CW = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     step;
  logic [CW-1:0]     cnt_nx;

  assign step   = dual ? CW'(2) : CW'(1);
  assign cnt_nx = cnt_q + step;
  assign done   = bit_en && (cnt_nx == CW'(BYTE_W));
  assign word   = dual ? {sh_q[BYTE_W-3:0], d0, d1} : {sh_q[BYTE_W-2:0], d0};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (bit_en) begin
      sh_q  <= word;
      cnt_q <= done ? '0 : cnt_nx;
    end
  end

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(BYTE_W));
  p_clear_resets_r6: assert property (@(posedge clk) disable iff (rst)
    clear |=> cnt_q == '0);
  p_dual_even_r3: assert property (@(posedge clk) disable iff (rst)
    (dual && !clear && bit_en) |=> !cnt_q[0] || clear);
endmodule

// File: rtl/dwr_cmd_rx.sv
module dwr_cmd_rx #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sel_n_i,
  input  logic              d0_i,
  input  logic              d1_i,
  input  logic              dual_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              byte_is_cmd_o
);
  import dwr_pkg::*;

  logic [SYNC_W-1:0] raw, syn;
  logic              clk_q, sel_q, mode_q, first_q;
  logic              sel_s, rise, sel_fall, eff_mode, done;
  logic [BYTE_W-1:0] word;

  always_comb begin
    raw = '0;
    raw[IDX_D0]  = d0_i;
    raw[IDX_D1]  = d1_i;
    raw[IDX_CLK] = sclk_i;
    raw[IDX_SEL] = sel_n_i;
    raw[IDX_MOD] = dual_i;
  end

  dwr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .din(raw), .dout(syn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= 1'b0;
      sel_q <= 1'b1;
    end else begin
      clk_q <= syn[IDX_CLK];
      sel_q <= syn[IDX_SEL];
    end
  end

  assign sel_s    = syn[IDX_SEL];
  assign rise     = syn[IDX_CLK] && !clk_q && !sel_s;
  assign sel_fall = sel_q && !sel_s;
  assign eff_mode = sel_fall ? syn[IDX_MOD] : mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else if (sel_fall) mode_q <= syn[IDX_MOD];
  end

  dwr_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .clear(sel_s), .bit_en(rise), .dual(eff_mode),
    .d0(syn[IDX_D0]), .d1(syn[IDX_D1]), .done(done), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q       <= 1'b1;
      byte_valid_o  <= 1'b0;
      byte_data_o   <= '0;
      byte_is_cmd_o <= 1'b0;
    end else begin
      byte_valid_o <= done;
      if (sel_s) first_q <= 1'b1;
      else if (done) first_q <= 1'b0;
      if (done) begin
        byte_data_o   <= word;
        byte_is_cmd_o <= first_q;
      end
    end
  end

  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |=> !byte_valid_o);
  p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !byte_valid_o |-> $stable(byte_data_o));
  p_no_byte_deselected_r7: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> !$past(sel_s));
  p_mode_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (!sel_s && !sel_fall) |=> $stable(mode_q));
  p_cmd_once_r5: assert property (@(posedge clk) disable iff (rst)
    (byte_valid_o && !sel_s) |=> !first_q || sel_s || $past(sel_s));
endmodule

// File: tb/tb_dwr_cmd_rx.sv
module tb_dwr_cmd_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_i = 1'b1, sel_n_i = 1'b1, d0_i = 1'b0, d1_i = 1'b0, dual_i = 1'b0;
  logic       byte_valid_o, byte_is_cmd_o;
  logic [7:0] byte_data_o;

  int n_tests = 0, n_fail = 0;
  int n_got = 0;
  logic [7:0] got_d [8];
  logic       got_c [8];
  logic       prev_v = 1'b0;

  always #4 clk = ~clk;

  dwr_cmd_rx dut (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .sel_n_i(sel_n_i), .d0_i(d0_i),
    .d1_i(d1_i), .dual_i(dual_i), .byte_valid_o(byte_valid_o),
    .byte_data_o(byte_data_o), .byte_is_cmd_o(byte_is_cmd_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid_o) begin
        if (n_got < 8) begin
          got_d[n_got] = byte_data_o;
          got_c[n_got] = byte_is_cmd_o;
        end
        n_got++;
        if (prev_v) begin
          n_tests++; n_fail++;
          $display("FAIL R4 strobe width actual=2 expected=1");
        end
      end
      prev_v = byte_valid_o;
    end
  end

  task automatic bit_edge(input logic a, input logic b);
    sclk_i = 1'b0; d0_i = a; d1_i = b;
    repeat (4) @(negedge clk);
    sclk_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic dual);
    if (dual) for (int i = 3; i >= 0; i--) bit_edge(v[2*i+1], v[2*i]);
    else      for (int i = 7; i >= 0; i--) bit_edge(v[i], ~v[i]);
  endtask

  task automatic sel_on();
    n_got = 0;
    sel_n_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (6) @(negedge clk);
    sel_n_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic frame2(input logic [7:0] a, input logic [7:0] b, input logic dual, input string tag);
    dual_i = dual;
    sel_on();
    send_byte(a, dual);
    send_byte(b, dual);
    sel_off();
    check(n_got == 2 && got_d[0] == a && got_d[1] == b && got_c[0] && !got_c[1],
          tag, {n_got[7:0], got_d[0], got_d[1], 7'b0, got_c[0]},
          {8'd2, a, b, 8'd1});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(byte_valid_o == 0 && byte_data_o == 0 && byte_is_cmd_o == 0, "R1 in reset",
          {byte_valid_o, byte_data_o, byte_is_cmd_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(byte_valid_o == 0 && byte_data_o == 0 && byte_is_cmd_o == 0, "R1 after reset",
          {byte_valid_o, byte_data_o, byte_is_cmd_o}, 0);
    repeat (4) @(negedge clk);

    // R2 R5 R10: single-wire sweep of every byte value
    for (int v = 0; v < 256; v++) frame2(8'(v), ~8'(v), 1'b0, "R2 R5 R10 single");
    // R3 R5 R10: dual-wire sweep
    for (int v = 0; v < 256; v++) frame2(8'(v), 8'(v * 37 + 11), 1'b1, "R3 R5 R10 dual");

    // R4: data held after strobe
    repeat (10) @(negedge clk);
    check(byte_data_o == 8'(255 * 37 + 11), "R4 hold", byte_data_o, 8'(255 * 37 + 11));

    // R6: partial byte dropped
    dual_i = 1'b0;
    sel_on();
    for (int i = 0; i < 5; i++) bit_edge(1'b1, 1'b0);
    sel_off();
    check(n_got == 0, "R6 partial dropped", n_got, 0);
    frame2(8'hA5, 8'h3C, 1'b0, "R6 fresh frame");

    // R7: edges while deselected
    n_got = 0;
    for (int i = 0; i < 16; i++) bit_edge(1'b1, 1'b1);
    repeat (6) @(negedge clk);
    check(n_got == 0, "R7 deselected edges", n_got, 0);
    frame2(8'h5A, 8'hC3, 1'b1, "R7 after foreign traffic");

    // R8: mode flip inside a frame has no effect
    dual_i = 1'b1;
    sel_on();
    dual_i = 1'b0;
    send_byte(8'h96, 1'b1);
    send_byte(8'h1E, 1'b1);
    sel_off();
    check(n_got == 2 && got_d[0] == 8'h96 && got_d[1] == 8'h1E, "R8 mode frozen",
          {got_d[0], got_d[1]}, 16'h961E);
    frame2(8'h81, 8'h7E, 1'b0, "R8 next frame new mode");

    // R9: last edge together with deselect
    dual_i = 1'b0;
    sel_on();
    for (int i = 0; i < 7; i++) bit_edge(1'b1, 1'b0);
    sclk_i = 1'b0; d0_i = 1'b1;
    repeat (4) @(negedge clk);
    sclk_i = 1'b1; sel_n_i = 1'b1;
    repeat (10) @(negedge clk);
    check(n_got == 0, "R9 collision discards", n_got, 0);
    // R9: select fall together with first edge counts that edge
    n_got = 0;
    dual_i = 1'b1;
    sclk_i = 1'b0; d0_i = 1'b1; d1_i = 1'b0;
    repeat (4) @(negedge clk);
    sclk_i = 1'b1; sel_n_i = 1'b0;
    repeat (4) @(negedge clk);
    bit_edge(1'b0, 1'b1);
    bit_edge(1'b1, 1'b1);
    bit_edge(1'b0, 1'b0);
    sel_off();
    check(n_got == 1 && got_d[0] == 8'h9C && got_c[0], "R9 fall with edge",
          {n_got[7:0], got_d[0]}, 16'h019C);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule